// File: doc/BRIEF.md
# Password-Unlocked Flash Test Control Register

This block is the 32-bit control word for a flash controller's user test mode, along with three companion test registers: a match address and the two halves of a 64-bit injected data word. Test mode starts locked. Software unlocks it by writing one exact 32-bit key to the control word while no program or erase is requested. While test mode is locked, the control fields and the companion registers ignore bus writes.

Test mode can be left only by a write that clears the enable bit. That write succeeds only when the integrity check reports done and neither the integrity-enable bit nor the data-injection bit is set. When unlocked, the block drives the margin-read, sequence-select, integrity-enable, correction-logging and ECC-injection controls.

A registered read multiplexer sits in the array read path. When injection is enabled and the read address equals the stored match address, it returns the injected word and the injected check bits in place of the array data.

The lock logic has two states. In LOCKED, a key write with both request inputs low takes transition UNLOCK_OK into UNLOCKED. In UNLOCKED, a write with bit 31 low that meets the clear conditions takes transition CLEAR_OK back to LOCKED. Every other write leaves the state unchanged.

Top module: `flash_test_ctl`

## Requirements
- R1: After reset, test mode is locked. Every control output is 0, and reading the control word (select 0) returns 0 except bit 0, which shows `integ_done`.
- R2: Test mode unlocks (`test_en`=1) only after a write to select 0 whose value equals 0xF9F9_9999 exactly. Writing bit 31 alone, or any other value, leaves the block locked and changes nothing. Accepting the key leaves all the other fields unchanged.
- R3: A key write is ignored while `pgm_req` or `ers_req` is 1.
- R4: A write to select 0 with bit 31 low locks test mode only if `integ_done` is 1 and both the integrity-enable bit (bit 1) and the injection bit (bit 3) are currently 0. Otherwise the block stays unlocked.
- R5: In the write that locks test mode, requests to set bit 1 or bit 3 are ignored, so both bits read 0 afterwards.
- R6: While locked, writes to the control fields and to the companion registers have no effect. The companion registers are select 1 (match address, low bits), select 2 (data bits 31:0) and select 3 (data bits 63:32).
- R7: Margin enable (bit 5) and margin value (bit 4) change only in a write made while `integ_done` is 1.
- R8: Bits 23:16 hold the 8 injected check bits, and bit 30 is the correction-logging enable. Bits 29:24 and 15:6 always read 0.
- R9: One cycle after `rd_req`, `rd_valid` is 1 and `rd_data`/`rd_chk` are registered. They carry the injected word and check bits if bit 3 is set and `rd_addr` equals the match address (`rd_hit`=1). Otherwise they carry `arr_data`/`arr_chk`.
- R10: `seq_linear` is 1 only when the sequence bit (bit 2) is 1 and margin enable is 0.
- R11: `corr_logged` is `corr_event` delayed by one cycle, gated by the correction-logging enable. An event seen while that enable is 0 is never logged.
- R12: Bit 0 of the control word is read-only and reflects `integ_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_sel | input | REG_SEL_W | Register select (0 control, 1 address, 2 data low, 3 data high) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the selected register |
| pgm_req | input | 1 | Program operation requested |
| ers_req | input | 1 | Erase operation requested |
| integ_done | input | 1 | Integrity check done |
| test_en | output | 1 | Test mode unlocked |
| sbc_en | output | 1 | Correction-logging enable |
| margin_en | output | 1 | Margin read enable |
| margin_val | output | 1 | Margin level (1 erased, 0 programmed) |
| seq_linear | output | 1 | Sequential integrity address order in effect |
| integ_en | output | 1 | Integrity-check enable bit |
| inject_en | output | 1 | ECC data injection enable |
| corr_event | input | 1 | Single-bit correction seen by the ECC logic |
| corr_logged | output | 1 | Correction recorded |
| rd_req | input | 1 | Array read request |
| rd_addr | input | ARR_AW | Array read address |
| arr_data | input | 64 | Data word from the array |
| arr_chk | input | 8 | Check bits from the array |
| rd_valid | output | 1 | Registered read result valid |
| rd_data | output | 64 | Registered read data |
| rd_chk | output | 8 | Registered check bits |
| rd_hit | output | 1 | Result came from the injection registers |

## Verification
The bench builds the block with `ARR_AW`=4 and `REG_SEL_W`=2. With those values, every match address can be crossed with every read address, with injection both off and on.

At 32 bits, the key is tried with each single bit flipped, so every near-miss that differs by one bit is covered. The clear conditions are swept over all eight combinations of done, integrity-enable and injection. The margin and sequence bits are swept over all four settings, with `integ_done` both high and low.

// File: rtl/ftc_pkg.sv
package ftc_pkg;
    localparam int REG_W  = 32;
    localparam int WORD_W = 64;
    localparam int CHK_W  = 8;

    typedef enum logic [0:0] {
        ST_LOCKED   = 1'b0,
        ST_UNLOCKED = 1'b1
    } lock_state_t;

    typedef struct packed {
        logic             sbc_en;
        logic [CHK_W-1:0] chk;
        logic             mre;
        logic             mrv;
        logic             eie;
        logic             ais;
        logic             aie;
    } ctl_fields_t;
endpackage

// File: rtl/ftc_lock_fsm.sv
module ftc_lock_fsm
    import ftc_pkg::*;
#(
    parameter logic [31:0] PASSWORD = 32'hF9F9_9999
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_wr,
    input  logic [REG_W-1:0] wdata,
    input  logic             pgm_req,
    input  logic             ers_req,
    input  logic             integ_done,
    input  logic             aie_cur,
    input  logic             eie_cur,
    output logic             unlocked,
    output logic             field_wr,
    output logic             clearing
);
    lock_state_t state, state_nx;
    logic unlock_ok, clear_ok;

    always_comb begin
        unlock_ok = ctl_wr && (wdata == PASSWORD) && !pgm_req && !ers_req;
        clear_ok  = ctl_wr && !wdata[REG_W-1] && integ_done && !aie_cur && !eie_cur;
        state_nx  = state;
        unique case (state)
            ST_LOCKED:   if (unlock_ok) state_nx = ST_UNLOCKED;
            ST_UNLOCKED: if (clear_ok)  state_nx = ST_LOCKED;
            default:                    state_nx = ST_LOCKED;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_LOCKED;
        else        state <= state_nx;
    end

    always_comb begin
        unlocked = 1'b0;
        field_wr = 1'b0;
        clearing = 1'b0;
        unique case (state)
            ST_LOCKED: ;
            ST_UNLOCKED: begin
                unlocked = 1'b1;
                field_wr = ctl_wr;
                clearing = clear_ok;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/ftc_ctl_fields.sv
module ftc_ctl_fields
    import ftc_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        field_wr,
    input  logic        clearing,
    input  logic        integ_done,
    input  ctl_fields_t wr_val,
    output ctl_fields_t cur
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur <= '0;
        end else if (field_wr) begin
            cur.sbc_en <= wr_val.sbc_en;
            cur.chk    <= wr_val.chk;
            cur.ais    <= wr_val.ais;
            cur.aie    <= clearing ? 1'b0 : wr_val.aie;
            cur.eie    <= clearing ? 1'b0 : wr_val.eie;
            if (integ_done) begin
                cur.mre <= wr_val.mre;
                cur.mrv <= wr_val.mrv;
            end
        end
    end
endmodule

// File: rtl/ftc_companion.sv
module ftc_companion
    import ftc_pkg::*;
#(
    parameter int ARR_AW    = 16,
    parameter int REG_SEL_W = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [REG_SEL_W-1:0] sel,
    input  logic [REG_W-1:0]     wdata,
    output logic [ARR_AW-1:0]    match_addr,
    output logic [WORD_W-1:0]    inj_word
);
    localparam int HALF_W = WORD_W / 2;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            match_addr <= '0;
        end else if (wr_en && sel == REG_SEL_W'(1)) begin
            match_addr <= wdata[ARR_AW-1:0];
        end
    end

    for (genvar h = 0; h < 2; h++) begin : g_half
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                inj_word[h*HALF_W +: HALF_W] <= '0;
            end else if (wr_en && sel == REG_SEL_W'(2 + h)) begin
                inj_word[h*HALF_W +: HALF_W] <= wdata[HALF_W-1:0];
            end
        end
    end
endmodule

// File: rtl/ftc_rd_mux.sv
module ftc_rd_mux
    import ftc_pkg::*;
#(
    parameter int ARR_AW = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_req,
    input  logic [ARR_AW-1:0] rd_addr,
    input  logic [WORD_W-1:0] arr_data,
    input  logic [CHK_W-1:0]  arr_chk,
    input  logic              inj_en,
    input  logic [ARR_AW-1:0] match_addr,
    input  logic [WORD_W-1:0] inj_word,
    input  logic [CHK_W-1:0]  inj_chk,
    output logic              rd_valid,
    output logic [WORD_W-1:0] rd_data,
    output logic [CHK_W-1:0]  rd_chk,
    output logic              rd_hit
);
    logic hit_nx;
    assign hit_nx = inj_en && (rd_addr == match_addr);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
            rd_chk   <= '0;
            rd_hit   <= 1'b0;
        end else begin
            rd_valid <= rd_req;
            if (rd_req) begin
                rd_hit  <= hit_nx;
                rd_data <= hit_nx ? inj_word : arr_data;
                rd_chk  <= hit_nx ? inj_chk  : arr_chk;
            end
        end
    end
endmodule

// File: rtl/flash_test_ctl.sv
module flash_test_ctl
    import ftc_pkg::*;
#(
    parameter logic [31:0] PASSWORD  = 32'hF9F9_9999,
    parameter int          ARR_AW    = 16,
    parameter int          REG_SEL_W = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_wr,
    input  logic [REG_SEL_W-1:0] bus_sel,
    input  logic [31:0]          bus_wdata,
    output logic [31:0]          bus_rdata,
    input  logic                 pgm_req,
    input  logic                 ers_req,
    input  logic                 integ_done,
    output logic                 test_en,
    output logic                 sbc_en,
    output logic                 margin_en,
    output logic                 margin_val,
    output logic                 seq_linear,
    output logic                 integ_en,
    output logic                 inject_en,
    input  logic                 corr_event,
    output logic                 corr_logged,
    input  logic                 rd_req,
    input  logic [ARR_AW-1:0]    rd_addr,
    input  logic [63:0]          arr_data,
    input  logic [7:0]           arr_chk,
    output logic                 rd_valid,
    output logic [63:0]          rd_data,
    output logic [7:0]           rd_chk,
    output logic                 rd_hit
);
    localparam int HALF_W = WORD_W / 2;

    logic        ctl_wr, field_wr, clearing;
    ctl_fields_t wr_val, cur;
    logic [ARR_AW-1:0] match_addr;
    logic [WORD_W-1:0] inj_word;

    assign ctl_wr = bus_wr && (bus_sel == '0);

    always_comb begin
        wr_val.sbc_en = bus_wdata[30];
        wr_val.chk    = bus_wdata[23:16];
        wr_val.mre    = bus_wdata[5];
        wr_val.mrv    = bus_wdata[4];
        wr_val.eie    = bus_wdata[3];
        wr_val.ais    = bus_wdata[2];
        wr_val.aie    = bus_wdata[1];
    end

    ftc_lock_fsm #(.PASSWORD(PASSWORD)) u_fsm (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .wdata(bus_wdata),
        .pgm_req(pgm_req), .ers_req(ers_req), .integ_done(integ_done),
        .aie_cur(cur.aie), .eie_cur(cur.eie),
        .unlocked(test_en), .field_wr(field_wr), .clearing(clearing)
    );

    ftc_ctl_fields u_fields (
        .clk(clk), .rst_n(rst_n), .field_wr(field_wr), .clearing(clearing),
        .integ_done(integ_done), .wr_val(wr_val), .cur(cur)
    );

    ftc_companion #(.ARR_AW(ARR_AW), .REG_SEL_W(REG_SEL_W)) u_comp (
        .clk(clk), .rst_n(rst_n), .wr_en(bus_wr && test_en), .sel(bus_sel),
        .wdata(bus_wdata), .match_addr(match_addr), .inj_word(inj_word)
    );

    ftc_rd_mux #(.ARR_AW(ARR_AW)) u_rdmux (
        .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_addr(rd_addr),
        .arr_data(arr_data), .arr_chk(arr_chk), .inj_en(cur.eie),
        .match_addr(match_addr), .inj_word(inj_word), .inj_chk(cur.chk),
        .rd_valid(rd_valid), .rd_data(rd_data), .rd_chk(rd_chk), .rd_hit(rd_hit)
    );

    assign sbc_en     = cur.sbc_en;
    assign margin_en  = cur.mre;
    assign margin_val = cur.mrv;
    assign seq_linear = cur.ais && !cur.mre;
    assign integ_en   = cur.aie;
    assign inject_en  = cur.eie;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) corr_logged <= 1'b0;
        else        corr_logged <= corr_event && cur.sbc_en;
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_sel)
            REG_SEL_W'(0): bus_rdata = {test_en, cur.sbc_en, 6'b0, cur.chk, 10'b0,
                                        cur.mre, cur.mrv, cur.eie, cur.ais, cur.aie,
                                        integ_done};
            REG_SEL_W'(1): bus_rdata = {{(32-ARR_AW){1'b0}}, match_addr};
            REG_SEL_W'(2): bus_rdata = inj_word[HALF_W-1:0];
            REG_SEL_W'(3): bus_rdata = inj_word[WORD_W-1:HALF_W];
            default:       bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/ftc_checker.sv
module ftc_checker #(
    parameter logic [31:0] PASSWORD  = 32'hF9F9_9999,
    parameter int          REG_SEL_W = 2
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 bus_wr,
    input logic [REG_SEL_W-1:0] bus_sel,
    input logic [31:0]          bus_wdata,
    input logic                 pgm_req,
    input logic                 ers_req,
    input logic                 integ_done,
    input logic                 test_en,
    input logic                 sbc_en,
    input logic                 margin_en,
    input logic                 margin_val,
    input logic                 integ_en,
    input logic                 inject_en,
    input logic                 corr_event,
    input logic                 corr_logged,
    input logic                 rd_req,
    input logic                 rd_valid
);
    // R2
    key_only_unlock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(test_en) |-> $past(bus_wr && bus_sel == '0 && bus_wdata == PASSWORD));

    // R3
    busy_key_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!test_en && bus_wr && bus_sel == '0 && (pgm_req || ers_req)) |=> !test_en);

    // R4
    clear_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(test_en) |-> $past(integ_done && !integ_en && !inject_en));

    // R5
    clear_no_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(test_en) |-> (!integ_en && !inject_en));

    // R7
    margin_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_sel == '0 && !integ_done) |=> ($stable(margin_en) && $stable(margin_val)));

    // R9
    rd_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> rd_valid);

    // R11
    corr_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (corr_event && !sbc_en) |=> !corr_logged);
endmodule

bind flash_test_ctl ftc_checker #(.PASSWORD(PASSWORD), .REG_SEL_W(REG_SEL_W)) i_chk (.*);

// File: tb/test_flash_test_ctl.sv
module test_flash_test_ctl;
    localparam int          CLK_PERIOD = 10;
    localparam int          AW         = 4;
    localparam logic [31:0] KEY        = 32'hF9F9_9999;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_sel = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        pgm_req = 1'b0, ers_req = 1'b0, integ_done = 1'b0;
    logic        test_en, sbc_en, margin_en, margin_val, seq_linear, integ_en, inject_en;
    logic        corr_event = 1'b0;
    logic        corr_logged;
    logic        rd_req = 1'b0;
    logic [AW-1:0] rd_addr = '0;
    logic [63:0] arr_data = '0;
    logic [7:0]  arr_chk = '0;
    logic        rd_valid, rd_hit;
    logic [63:0] rd_data;
    logic [7:0]  rd_chk;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    flash_test_ctl #(.PASSWORD(KEY), .ARR_AW(AW), .REG_SEL_W(2)) i_flash_test_ctl (.*);

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] s, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_sel = s; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rdreg(input logic [1:0] s, output logic [31:0] v);
        bus_sel = s;
        #1;
        v = bus_rdata;
    endtask

    task automatic unlock();
        if (!test_en) wr(2'd0, KEY);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        checks++; errors++;
        $display("FAIL R0 watchdog actual=running expected=done");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rdreg(2'd0, v); chk("R1 ctl readback", v, 0);
        chk("R1 outputs", {test_en, sbc_en, margin_en, margin_val, seq_linear,
                           integ_en, inject_en, corr_logged, rd_valid}, 0);

        // R6 locked writes ignored
        wr(2'd0, 32'h7FFF_FFFF);
        rdreg(2'd0, v); chk("R6 ctl locked", v, 0);
        for (int s = 1; s < 4; s++) begin
            wr(2'(s), 32'hFFFF_FFFF);
            rdreg(2'(s), v); chk("R6 companion locked", v, 0);
        end

        // R2 near-miss keys
        for (int b = 0; b < 32; b++) begin
            wr(2'd0, KEY ^ (32'd1 << b));
            chk("R2 near key", test_en, 0);
        end
        wr(2'd0, 32'h8000_0000);
        chk("R2 bit31 only", test_en, 0);

        // R3 busy key ignored
        pgm_req = 1'b1; wr(2'd0, KEY); chk("R3 pgm busy", test_en, 0);
        pgm_req = 1'b0; ers_req = 1'b1; wr(2'd0, KEY); chk("R3 ers busy", test_en, 0);
        ers_req = 1'b0; wr(2'd0, KEY); chk("R2 key accepted", test_en, 1);
        rdreg(2'd0, v); chk("R2 fields unchanged", v, 32'h8000_0000);

        // R8 R7 reserved bits and margin lock
        wr(2'd0, 32'hFFFF_FFFF);
        rdreg(2'd0, v); chk("R8 R7 readback", v, 32'hC0FF_000E);
        // R12 done bit visible, read-only
        integ_done = 1'b1;
        rdreg(2'd0, v); chk("R12 done bit", v, 32'hC0FF_000F);
        wr(2'd0, 32'hFFFF_FFFE);
        rdreg(2'd0, v); chk("R7 R12 margin set", v, 32'hC0FF_003F);

        // R7 R10 margin and sequence sweep
        for (int m = 0; m < 4; m++) begin
            for (int a = 0; a < 2; a++) begin
                integ_done = 1'b1;
                wr(2'd0, 32'h8000_0000 | (32'(m) << 4) | (32'(a) << 2));
                chk("R7 margin_en", margin_en, 64'((m >> 1) & 1));
                chk("R7 margin_val", margin_val, 64'(m & 1));
                chk("R10 seq_linear", seq_linear, 64'(a & ~(m >> 1) & 1));
                integ_done = 1'b0;
                wr(2'd0, 32'h8000_0000 | (32'(3 - m) << 4));
                chk("R7 margin held", {margin_en, margin_val}, 64'(m));
            end
        end

        // R4 clear condition sweep
        for (int c = 0; c < 8; c++) begin
            integ_done = 1'b1;
            unlock();
            wr(2'd0, 32'h8000_0000 | (32'((c >> 1) & 1) << 3) | (32'(c & 1) << 1));
            integ_done = c[2];
            wr(2'd0, 32'h0);
            chk("R4 clear gate", test_en, 64'(!(c[2] && !c[1] && !c[0])));
        end

        // R5 clear write ignores set of bits 1 and 3
        integ_done = 1'b1;
        unlock();
        wr(2'd0, 32'h8000_0000);
        wr(2'd0, 32'h0000_000A);
        chk("R5 locked", test_en, 0);
        chk("R5 aie eie", {integ_en, inject_en}, 0);
        rdreg(2'd0, v); chk("R5 readback", v & 32'h0000_000A, 0);

        // R6 companion locked after clear
        unlock();
        wr(2'd1, 32'd5);
        wr(2'd0, 32'h0);
        wr(2'd1, 32'd9);
        rdreg(2'd1, v); chk("R6 address held", v, 5);

        // R9 read mux sweep
        unlock();
        for (int st = 0; st < 16; st++) begin
            logic [7:0] ck;
            ck = 8'(st * 7 + 3);
            wr(2'd1, 32'(st));
            wr(2'd2, 32'hA5A5_0000 | 32'(st));
            wr(2'd3, 32'h5A5A_0000 | 32'(st));
            for (int e = 0; e < 2; e++) begin
                wr(2'd0, 32'h8000_0000 | (32'(ck) << 16) | (32'(e) << 3));
                for (int ra = 0; ra < 16; ra++) begin
                    logic hit;
                    hit = (e == 1) && (ra == st);
                    @(negedge clk);
                    rd_req = 1'b1; rd_addr = AW'(ra);
                    arr_data = {32'hDEAD_0000 | 32'(ra), 32'hBEEF_0000 | 32'(ra)};
                    arr_chk = 8'(ra) ^ 8'h5A;
                    @(negedge clk);
                    rd_req = 1'b0;
                    chk("R9 valid", rd_valid, 1);
                    chk("R9 hit", rd_hit, 64'(hit));
                    chk("R9 data", rd_data, hit ? {32'h5A5A_0000 | 32'(st), 32'hA5A5_0000 | 32'(st)}
                                                : {32'hDEAD_0000 | 32'(ra), 32'hBEEF_0000 | 32'(ra)});
                    chk("R9 chk", rd_chk, hit ? 64'(ck) : 64'(8'(ra) ^ 8'h5A));
                end
            end
        end
        @(negedge clk);
        chk("R9 valid drops", rd_valid, 0);

        // R11 correction logging
        for (int s = 0; s < 2; s++) begin
            wr(2'd0, 32'h8000_0000 | (32'(s) << 30));
            @(negedge clk); corr_event = 1'b1;
            @(negedge clk); corr_event = 1'b0;
            chk("R11 corr_logged", corr_logged, 64'(s));
            @(negedge clk);
            chk("R11 corr clears", corr_logged, 0);
        end

        finish_run();
    end
endmodule